// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two square integer matrices of dimension DIM by running them through a DIM×DIM grid of multiply-accumulate cells. Each cell owns one element of the result and keeps its running sum in place. Left-matrix operands enter at the left edge and move one cell to the right per cycle. Right-matrix operands enter at the top edge and move one cell down per cycle. The edge feeders skew each lane by its index, so matching operand pairs meet in the correct cell on the same cycle.

The caller places both whole matrices on two packed ports and pulses `load` for one cycle. The block copies both matrices into local registers and clears every accumulator. It then steps through a fixed schedule of 3·DIM−2 cycles. At the end it raises `done` for exactly one cycle. The full product is then present on `mat_c` and stays there until the next accepted load. A load strobe that arrives while a product is being formed is ignored. Reset is asynchronous.

Top module: `omm_array`

## Requirements
- R1: DIM may be set from 3 to 16 and defaults to 4. ACC_W must be larger than 2·IN_W. Any other setting is rejected at elaboration. With the defaults, one product takes 10 cycles.
- R2: Operands are IN_W-bit (default 8) signed two's-complement values. Each result element is the ACC_W-bit (default 32) signed sum over k of A[r][k]·B[k][c], with every product sign-extended. Element (r,c) of a matrix sits at bit offset (r·DIM+c)·width of its packed port.
- R3: `mat_a` and `mat_b` are sampled only on a clock edge where `load` is high and no product is in progress. Changes on them at any other time have no effect on the result.
- R4: `done` rises exactly 3·DIM−2 cycles after the edge that accepted the load, and never without a prior accepted load.
- R5: `done` is high for exactly one cycle per accepted load.
- R6: `mat_c` is valid when `done` is high and holds its value until the next accepted load.
- R7: A `load` strobe that arrives while a product is in progress is ignored. It neither restarts the schedule nor changes the result.
- R8: Every accumulator is cleared when a load is accepted, so no earlier result leaks into the next one.
- R9: Asserting the asynchronous reset forces `done` low and `mat_c` to zero at once, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| load | input | 1 | Strobe that accepts both operand matrices |
| mat_a | input | DIM·DIM·IN_W | Left operand matrix, packed row-major |
| mat_b | input | DIM·DIM·IN_W | Right operand matrix, packed row-major |
| done | output | 1 | One-cycle pulse when the product is complete |
| mat_c | output | DIM·DIM·ACC_W | Result matrix, packed row-major |

## Verification
Directed matrices cover several distinct cases:
- An identity left operand shows whether operands reach the right cells. Any skew or routing error moves the right-hand values out of place.
- Matrices filled with the most negative code, and a pairing of the most negative code with the most positive code, test sign extension and the largest sums.
- An all-zero product run right after a nonzero one shows whether the accumulators are cleared on load.

Seeded random matrices cover the general case. Some random runs scramble the operand ports and pulse `load` in the middle of the schedule. A result that still matches the first operands separates correct capture-once behaviour from re-sampling or restarting. A reset asserted mid-run is checked with no clock edge, which confirms that the reset is asynchronous.

// File: rtl/omm_pkg.sv
package omm_pkg;

   // Number of accumulate cycles needed for a DIM x DIM product.
   function automatic int run_cycles(input int dim);
      return 3 * dim - 2;
   endfunction

   // Bits needed to count the accumulate steps.
   function automatic int step_bits(input int dim);
      return $clog2(run_cycles(dim));
   endfunction

endpackage

// File: rtl/omm_seq.sv
module omm_seq #(
   parameter int LAST   = 9,
   parameter int STEP_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   output logic              accept,
   output logic              run,
   output logic [STEP_W-1:0] step,
   output logic              done
);

   assign accept = load & ~run;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         run  <= 1'b0;
         step <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            run  <= 1'b1;
            step <= '0;
         end else if (run) begin
            if (step == STEP_W'(LAST)) begin
               run  <= 1'b0;
               done <= 1'b1;
            end else begin
               step <= step + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/omm_feed.sv
module omm_feed #(
   parameter int DIM    = 4,
   parameter int W      = 8,
   parameter int LANE   = 0,
   parameter int STEP_W = 4
) (
   input  logic                run,
   input  logic [STEP_W-1:0]   step,
   input  logic [DIM*W-1:0]    lane_vec,
   output logic signed [W-1:0] elem
);

   // Lane LANE is delayed by LANE steps: element k enters at step k+LANE.
   always_comb begin
      elem = '0;
      for (int k = 0; k < DIM; k++) begin
         if (run && step == STEP_W'(k + LANE))
            elem = lane_vec[k*W +: W];
      end
   end

endmodule

// File: rtl/omm_cell.sv
module omm_cell #(
   parameter int IN_W  = 8,
   parameter int ACC_W = 32
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    clr,
   input  logic                    en,
   input  logic signed [IN_W-1:0]  h_in,
   input  logic signed [IN_W-1:0]  v_in,
   output logic signed [IN_W-1:0]  h_out,
   output logic signed [IN_W-1:0]  v_out,
   output logic signed [ACC_W-1:0] acc
);

   localparam int PW = 2 * IN_W;

   logic signed [PW-1:0]    prod;
   logic signed [ACC_W-1:0] prod_ext;

   assign prod     = h_in * v_in;
   assign prod_ext = {{(ACC_W-PW){prod[PW-1]}}, prod};

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         h_out <= '0;
         v_out <= '0;
         acc   <= '0;
      end else if (clr) begin
         h_out <= '0;
         v_out <= '0;
         acc   <= '0;
      end else if (en) begin
         h_out <= h_in;
         v_out <= v_in;
         acc   <= acc + prod_ext;
      end
   end

endmodule

// File: rtl/omm_array.sv
module omm_array #(
   parameter int DIM   = 4,
   parameter int IN_W  = 8,
   parameter int ACC_W = 32
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     load,
   input  logic [DIM*DIM*IN_W-1:0]  mat_a,
   input  logic [DIM*DIM*IN_W-1:0]  mat_b,
   output logic                     done,
   output logic [DIM*DIM*ACC_W-1:0] mat_c
);

   localparam int LAST   = omm_pkg::run_cycles(DIM) - 1;
   localparam int STEP_W = omm_pkg::step_bits(DIM);
   localparam int MAT_W  = DIM * DIM * IN_W;

   if (DIM < 3 || DIM > 16) begin : g_bad_dim
      $error("omm_array: DIM must lie in 3..16");
   end
   if (ACC_W <= 2 * IN_W) begin : g_bad_acc
      $error("omm_array: ACC_W must exceed twice IN_W");
   end

   logic              accept;
   logic              run;
   logic [STEP_W-1:0] step;
   logic [MAT_W-1:0]  a_q;
   logic [MAT_W-1:0]  b_q;

   omm_seq #(.LAST(LAST), .STEP_W(STEP_W)) u_seq (
      .clk   (clk),
      .rst   (rst),
      .load  (load),
      .accept(accept),
      .run   (run),
      .step  (step),
      .done  (done)
   );

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         a_q <= '0;
         b_q <= '0;
      end else if (accept) begin
         a_q <= mat_a;
         b_q <= mat_b;
      end
   end

   // Horizontal links: column index DIM is the unused right edge.
   logic signed [IN_W-1:0] h_lnk [DIM][DIM+1];
   // Vertical links: row index DIM is the unused bottom edge.
   logic signed [IN_W-1:0] v_lnk [DIM+1][DIM];

   for (genvar r = 0; r < DIM; r++) begin : g_row_feed
      omm_feed #(.DIM(DIM), .W(IN_W), .LANE(r), .STEP_W(STEP_W)) u_feed (
         .run     (run),
         .step    (step),
         .lane_vec(a_q[r*DIM*IN_W +: DIM*IN_W]),
         .elem    (h_lnk[r][0])
      );
   end

   for (genvar c = 0; c < DIM; c++) begin : g_col_feed
      logic [DIM*IN_W-1:0] col_vec;
      for (genvar k = 0; k < DIM; k++) begin : g_gather
         assign col_vec[k*IN_W +: IN_W] = b_q[(k*DIM+c)*IN_W +: IN_W];
      end
      omm_feed #(.DIM(DIM), .W(IN_W), .LANE(c), .STEP_W(STEP_W)) u_feed (
         .run     (run),
         .step    (step),
         .lane_vec(col_vec),
         .elem    (v_lnk[0][c])
      );
   end

   for (genvar r = 0; r < DIM; r++) begin : g_r
      for (genvar c = 0; c < DIM; c++) begin : g_c
         logic signed [ACC_W-1:0] acc;
         omm_cell #(.IN_W(IN_W), .ACC_W(ACC_W)) u_cell (
            .clk  (clk),
            .rst  (rst),
            .clr  (accept),
            .en   (run),
            .h_in (h_lnk[r][c]),
            .v_in (v_lnk[r][c]),
            .h_out(h_lnk[r][c+1]),
            .v_out(v_lnk[r+1][c]),
            .acc  (acc)
         );
         assign mat_c[(r*DIM+c)*ACC_W +: ACC_W] = acc;
      end
   end

endmodule

// File: rtl/omm_array_chk.sv
module omm_array_chk #(
   parameter int DIM    = 4,
   parameter int C_BITS = 512
) (
   input logic              clk,
   input logic              rst,
   input logic              load,
   input logic              done,
   input logic [C_BITS-1:0] mat_c
);

   localparam int LAT = omm_pkg::run_cycles(DIM);

   // Port-level model of acceptance: a load is taken only while idle.
   logic active;
   int   cnt;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         active <= 1'b0;
         cnt    <= 0;
      end else if (!active && load) begin
         active <= 1'b1;
         cnt    <= 0;
      end else if (active) begin
         cnt <= cnt + 1;
         if (cnt == LAT - 1) active <= 1'b0;
      end
   end

   // R4 / R7: done appears exactly LAT cycles after the first accepted load
   p_latency_r4: assert property (@(posedge clk) disable iff (rst)
      done |-> (!active && cnt == LAT));

   // R4 / R7: no completion while the schedule is still running
   p_quiet_busy_r7: assert property (@(posedge clk) disable iff (rst)
      active |-> !done);

   // R5: completion is a single-cycle pulse
   p_pulse_r5: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R6: idle and no load means the result holds
   p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (!active && !load) |=> $stable(mat_c));

endmodule

bind omm_array omm_array_chk #(.DIM(DIM), .C_BITS(DIM*DIM*ACC_W)) u_chk (
   .clk  (clk),
   .rst  (rst),
   .load (load),
   .done (done),
   .mat_c(mat_c)
);

// File: tb/omm_array_tb.sv
module omm_array_tb;

   localparam int DIM   = 4;
   localparam int IN_W  = 8;
   localparam int ACC_W = 32;
   localparam int LAT   = 3 * DIM - 2;
   localparam int AW    = DIM * DIM * IN_W;
   localparam int CW    = DIM * DIM * ACC_W;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          load = 1'b0;
   logic [AW-1:0] mat_a = '0;
   logic [AW-1:0] mat_b = '0;
   logic          done;
   logic [CW-1:0] mat_c;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   omm_array u_dut (
      .clk  (clk),
      .rst  (rst),
      .load (load),
      .mat_a(mat_a),
      .mat_b(mat_b),
      .done (done),
      .mat_c(mat_c)
   );

   function automatic logic [CW-1:0] ref_mul(input logic [AW-1:0] a, input logic [AW-1:0] b);
      logic [CW-1:0] res = '0;
      for (int r = 0; r < DIM; r++) begin
         for (int c = 0; c < DIM; c++) begin
            int sum = 0;
            for (int k = 0; k < DIM; k++) begin
               logic signed [IN_W-1:0] x = a[(r*DIM+k)*IN_W +: IN_W];
               logic signed [IN_W-1:0] y = b[(k*DIM+c)*IN_W +: IN_W];
               sum += int'(x) * int'(y);
            end
            res[(r*DIM+c)*ACC_W +: ACC_W] = sum;
         end
      end
      return res;
   endfunction

   function automatic logic [AW-1:0] rand_mat();
      logic [AW-1:0] m;
      for (int i = 0; i < DIM*DIM; i++) m[i*IN_W +: IN_W] = IN_W'($urandom());
      return m;
   endfunction

   function automatic logic [AW-1:0] fill_mat(input logic [IN_W-1:0] v);
      logic [AW-1:0] m;
      for (int i = 0; i < DIM*DIM; i++) m[i*IN_W +: IN_W] = v;
      return m;
   endfunction

   function automatic logic [AW-1:0] ident_mat();
      logic [AW-1:0] m = '0;
      for (int i = 0; i < DIM; i++) m[(i*DIM+i)*IN_W +: IN_W] = IN_W'(1);
      return m;
   endfunction

   task automatic chk_mat(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_int(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Load a pair, optionally scrambling inputs and re-pulsing load mid-run.
   task automatic run_case(input string name, input logic [AW-1:0] a,
                           input logic [AW-1:0] b, input bit disturb);
      int            lat = 0;
      logic [CW-1:0] held;
      logic [CW-1:0] exp = ref_mul(a, b);
      @(negedge clk);
      mat_a = a;
      mat_b = b;
      load  = 1'b1;
      @(negedge clk);
      load = 1'b0;
      while (lat < LAT + 20) begin
         @(negedge clk);
         lat++;
         if (done) break;
         if (disturb && lat == 2) begin
            mat_a = rand_mat();
            mat_b = ~b;
            load  = 1'b1;
         end else begin
            load = 1'b0;
         end
      end
      load = 1'b0;
      chk_int({name, " R4 R1 latency"}, lat, LAT);
      chk_mat({name, disturb ? " R3 R7 result" : " R2 R8 result"}, mat_c, exp);
      held = mat_c;
      @(negedge clk);
      chk_int({name, " R5 pulse width"}, int'(done), 0);
      repeat (3) @(negedge clk);
      chk_mat({name, " R6 hold"}, mat_c, held);
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : main
      logic [CW-1:0] held;
      void'($urandom(32'd715));
      #1;
      chk_int("R9 done in reset", int'(done), 0);
      chk_mat("R9 result in reset", mat_c, '0);
      repeat (3) @(negedge clk);
      rst = 1'b0;

      run_case("identity", ident_mat(), rand_mat(), 1'b0);
      run_case("neg_full", fill_mat(8'h80), fill_mat(8'h80), 1'b0);
      run_case("neg_pos", fill_mat(8'h80), fill_mat(8'h7f), 1'b0);
      run_case("zero_after", '0, rand_mat(), 1'b0);

      for (int i = 0; i < 8; i++)
         run_case($sformatf("rand%0d", i), rand_mat(), rand_mat(), i[0]);

      // R3: inputs move without load; nothing may change
      held = mat_c;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         mat_a = rand_mat();
         mat_b = rand_mat();
      end
      @(negedge clk);
      chk_int("R3 no done without load", int'(done), 0);
      chk_mat("R3 result untouched without load", mat_c, held);

      // R9: asynchronous reset in the middle of a run
      @(negedge clk);
      mat_a = rand_mat();
      mat_b = rand_mat();
      load  = 1'b1;
      @(negedge clk);
      load = 1'b0;
      repeat (4) @(negedge clk);
      #1 rst = 1'b1;
      #1;
      chk_int("R9 async done", int'(done), 0);
      chk_mat("R9 async clear", mat_c, '0);
      @(negedge clk);
      rst = 1'b0;
      run_case("post_reset", rand_mat(), rand_mat(), 1'b0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule